// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the controller side of a single-data-rate SDRAM interface and watches the command pins and the address bus. On every rising clock edge with chip select low, it decodes the pin pattern into one of a small set of commands and splits the address into bank, row and column fields. It keeps a view of the four banks, recording whether each is open and which row was last activated in it. It also holds the last value loaded into the mode register, so the rest of the controller can see the same state the memory is in.

Every command is checked against that view. An access the memory would not accept raises a one-cycle error pulse and is ignored. Such an access is one to a closed bank, an activate to a bank that is already open, a refresh while a row is open, any access before the mode register has been loaded, or a write with auto-precharge while a full-page burst is selected. A legal write with auto-precharge keeps its bank open for the length of the burst and then closes it without a further command.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: During and after reset, until the first command is sampled, all four banks read closed, modeValid is low, cmdOut is 0 (no operation), err is low and the recorded rows and mode register are zero.
- R2: A command is sampled at a rising edge only when csN is low, and {rasN,casN,weN} selects it. 011 is activate (code 1) and 101 is read (code 2). 100 is write (code 3), or write with auto-precharge (code 4) when addr[10] is 1. 010 is single-bank precharge (code 5), or precharge-all (code 6) when addr[10] is 1. 001 is auto-refresh (code 7) and 000 is mode register set (code 8). A pattern of 111 or 110, or csN high, gives 0 (no operation). cmdOut, rowOut (addr[11:0]) and colOut (addr[9:0]) show the sampled command and its fields from the clock edge that sampled it until the next edge.
- R3: The bank index is addr[13]*2 + addr[12]. It is shown on bankOut and selects the bank that activate, read, write and single-bank precharge act on.
- R4: A legal activate opens the selected bank b and records addr[11:0] in openRows[12*b+11:12*b]. The recorded row is kept after the bank closes.
- R5: A single-bank precharge closes only the selected bank. A precharge to a closed bank is legal and changes nothing.
- R6: Precharge-all closes all four banks at once and cancels any pending auto-precharge. It never raises err.
- R7: A mode register set stores addr[13:0] on modeReg and raises modeValid, which stays high until reset.
- R8: While modeValid is low, activate, read, write and write with auto-precharge raise err and leave every bank unchanged.
- R9: A read or write to a closed bank, and an activate to an open bank, raise err and leave bank state and recorded rows unchanged.
- R10: Auto-refresh raises err if any bank is open, and is legal when all banks are closed.
- R11: A write with auto-precharge raises err and leaves its bank open when modeReg[9] is 0 and modeReg[2:0] is 100 to 111. Code 111 is a full-page burst, and codes 100 to 110 are reserved and treated the same way.
- R12: A legal write with auto-precharge issued at edge k closes its bank at edge k+L. L is 1, 2, 4 or 8 for modeReg[2:0] of 000, 001, 010 or 011, and L is 1 when modeReg[9] is 1. Until it closes, the bank reads open. An activate, read, write or single-bank precharge to that bank raises err and is ignored. Other banks may be used meanwhile.
- R13: err is high from the edge that sampled an offending command until the next edge, so it falls after one cycle unless the next command also offends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, commands sampled on rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe pin |
| casN | input | 1 | Column strobe pin |
| weN | input | 1 | Write enable pin |
| addr | input | 14 | Address bus, bank select in bits 13:12 |
| cmdOut | output | 4 | Decoded command code of the last sampled edge |
| bankOut | output | 2 | Bank index of the last sampled command |
| rowOut | output | 12 | Row field of the last sampled command |
| colOut | output | 10 | Column field of the last sampled command |
| err | output | 1 | One-cycle pulse for an illegal command |
| bankOpen | output | 4 | Open flag per bank, bit b for bank b |
| openRows | output | 48 | Last activated row per bank, 12 bits each |
| modeValid | output | 1 | High once a mode register set has been seen |
| modeReg | output | 14 | Current mode register contents |

## Verification
Two events can fall on one clock edge: a pending auto-precharge ends and closes its bank, and a new command arrives for another bank or for all banks. The bench provokes this in two ways. It issues a write with auto-precharge and places an activate to a different bank on exactly the L-th following edge. It also issues precharge-all while a burst-8 countdown is still running, and then leaves enough idle edges that a countdown that was not cancelled would close the bank again. A reference model that applies the countdown first and the new command second judges every output on every clock, and directed checks confirm that both effects show in the same cycle.

// File: rtl/sdct_pkg.sv
package sdct_pkg;
  localparam int ADDR_W   = 14;
  localparam int ROW_W    = 12;
  localparam int COL_W    = 10;
  localparam int NBANK    = 4;
  localparam int BANK_W   = $clog2(NBANK);
  localparam int BANK_LSB = ADDR_W - BANK_W;
  localparam int AP_BIT   = 10;
  localparam int SW_BIT   = 9;
  localparam int BL_W     = 3;
  localparam int MAX_BL   = 8;
  localparam int CNT_W    = $clog2(MAX_BL) + 1;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_WRA  = 4'd4,
    CMD_PRE  = 4'd5,
    CMD_PALL = 4'd6,
    CMD_REF  = 4'd7,
    CMD_MRS  = 4'd8
  } cmd_e;

  typedef struct packed {
    logic              actEn;
    logic              closeOne;
    logic              closeAll;
    logic              wraEn;
    logic              mrsEn;
    logic [BANK_W-1:0] bank;
  } strobes_t;

  // Write burst length for auto-precharge; zero marks an unusable setting.
  function automatic logic [CNT_W-1:0] burstLen(input logic [ADDR_W-1:0] m);
    logic [CNT_W-1:0] len;
    if (m[SW_BIT]) len = CNT_W'(1);
    else begin
      case (m[BL_W-1:0])
        3'b000:  len = CNT_W'(1);
        3'b001:  len = CNT_W'(2);
        3'b010:  len = CNT_W'(4);
        3'b011:  len = CNT_W'(8);
        default: len = '0;
      endcase
    end
    return len;
  endfunction
endpackage

// File: rtl/sdct_ctrl.sv
module sdct_ctrl
  import sdct_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  csN,
  input  logic                  rasN,
  input  logic                  casN,
  input  logic                  weN,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NBANK-1:0]      bankOpen,
  input  logic [NBANK-1:0]      bankPend,
  input  logic                  modeValid,
  input  logic [ADDR_W-1:0]     modeReg,
  output strobes_t              stb,
  output logic [3:0]            cmdOut,
  output logic [BANK_W-1:0]     bankOut,
  output logic [ROW_W-1:0]      rowOut,
  output logic [COL_W-1:0]      colOut,
  output logic                  err
);
  cmd_e              dec;
  cmd_e              cmdQ;
  logic [BANK_W-1:0] bankSel;
  logic              isOpen;
  logic              isPend;
  logic              bad;

  always_comb begin
    dec = CMD_NOP;
    if (!csN) begin
      case ({rasN, casN, weN})
        3'b011:  dec = CMD_ACT;
        3'b101:  dec = CMD_RD;
        3'b100:  dec = addr[AP_BIT] ? CMD_WRA : CMD_WR;
        3'b010:  dec = addr[AP_BIT] ? CMD_PALL : CMD_PRE;
        3'b001:  dec = CMD_REF;
        3'b000:  dec = CMD_MRS;
        default: dec = CMD_NOP;
      endcase
    end
  end

  assign bankSel = addr[BANK_LSB +: BANK_W];
  assign isOpen  = bankOpen[bankSel];
  assign isPend  = bankPend[bankSel];

  always_comb begin
    case (dec)
      CMD_ACT:       bad = !modeValid || isOpen;
      CMD_RD,
      CMD_WR:        bad = !modeValid || !isOpen || isPend;
      CMD_WRA:       bad = !modeValid || !isOpen || isPend || (burstLen(modeReg) == '0);
      CMD_PRE:       bad = isPend;
      CMD_REF:       bad = |bankOpen;
      default:       bad = 1'b0;
    endcase
  end

  always_comb begin
    stb.actEn    = (dec == CMD_ACT) && !bad;
    stb.closeOne = (dec == CMD_PRE) && !bad;
    stb.closeAll = (dec == CMD_PALL);
    stb.wraEn    = (dec == CMD_WRA) && !bad;
    stb.mrsEn    = (dec == CMD_MRS);
    stb.bank     = bankSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ    <= CMD_NOP;
      bankOut <= '0;
      rowOut  <= '0;
      colOut  <= '0;
      err     <= 1'b0;
    end else begin
      cmdQ    <= dec;
      bankOut <= bankSel;
      rowOut  <= addr[ROW_W-1:0];
      colOut  <= addr[COL_W-1:0];
      err     <= bad;
    end
  end

  assign cmdOut = cmdQ;

  // R8
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.actEn || stb.wraEn) |-> modeValid);

  // R13
  err_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (cmdOut != 4'd0 && cmdOut != 4'd6 && cmdOut != 4'd8));

  // R10
  ref_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdOut == 4'd7 && !err) |-> $past(bankOpen) == '0);
endmodule

// File: rtl/sdct_dp.sv
module sdct_dp
  import sdct_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  strobes_t               stb,
  input  logic [ADDR_W-1:0]      addr,
  output logic [NBANK-1:0]       bankOpen,
  output logic [NBANK-1:0]       bankPend,
  output logic [NBANK*ROW_W-1:0] openRows,
  output logic                   modeValid,
  output logic [ADDR_W-1:0]      modeReg
);
  logic [CNT_W-1:0] loadLen;
  assign loadLen = burstLen(modeReg);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic             openQ;
    logic [CNT_W-1:0] cntQ;
    logic [ROW_W-1:0] rowQ;
    logic             hit;

    assign hit = (stb.bank == BANK_W'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        openQ <= 1'b0;
        cntQ  <= '0;
        rowQ  <= '0;
      end else if (stb.closeAll) begin
        openQ <= 1'b0;
        cntQ  <= '0;
      end else if (cntQ == CNT_W'(1)) begin
        openQ <= 1'b0;
        cntQ  <= '0;
      end else if (cntQ != '0) begin
        cntQ  <= cntQ - CNT_W'(1);
      end else if (hit && stb.actEn) begin
        openQ <= 1'b1;
        rowQ  <= addr[ROW_W-1:0];
      end else if (hit && stb.closeOne) begin
        openQ <= 1'b0;
      end else if (hit && stb.wraEn) begin
        cntQ  <= loadLen;
      end
    end

    assign bankOpen[b] = openQ;
    assign bankPend[b] = (cntQ != '0);
    assign openRows[b*ROW_W +: ROW_W] = rowQ;

    // R12
    autopre_close_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(bankPend[b]) |-> !bankOpen[b]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeValid <= 1'b0;
      modeReg   <= '0;
    end else if (stb.mrsEn) begin
      modeValid <= 1'b1;
      modeReg   <= addr;
    end
  end

  // R9
  act_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.actEn |-> !bankOpen[stb.bank]);

  // R4
  act_opens_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.actEn |=> bankOpen[$past(stb.bank)]);

  // R6
  pall_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.closeAll |=> (bankOpen == '0 && bankPend == '0));

  // R11
  wra_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wraEn |-> (modeReg[SW_BIT] || !modeReg[2]));
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdct_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   csN,
  input  logic                   rasN,
  input  logic                   casN,
  input  logic                   weN,
  input  logic [ADDR_W-1:0]      addr,
  output logic [3:0]             cmdOut,
  output logic [BANK_W-1:0]      bankOut,
  output logic [ROW_W-1:0]       rowOut,
  output logic [COL_W-1:0]       colOut,
  output logic                   err,
  output logic [NBANK-1:0]       bankOpen,
  output logic [NBANK*ROW_W-1:0] openRows,
  output logic                   modeValid,
  output logic [ADDR_W-1:0]      modeReg
);
  strobes_t         stb;
  logic [NBANK-1:0] bankPend;

  sdct_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .bankOpen(bankOpen), .bankPend(bankPend),
    .modeValid(modeValid), .modeReg(modeReg), .stb(stb),
    .cmdOut(cmdOut), .bankOut(bankOut), .rowOut(rowOut), .colOut(colOut),
    .err(err)
  );

  sdct_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr),
    .bankOpen(bankOpen), .bankPend(bankPend), .openRows(openRows),
    .modeValid(modeValid), .modeReg(modeReg)
  );
endmodule

// File: tb/sim_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module sim_sdram_cmd_tracker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        rasN = 1'b1;
  logic        casN = 1'b1;
  logic        weN = 1'b1;
  logic [13:0] addr = '0;
  logic [3:0]  cmdOut;
  logic [1:0]  bankOut;
  logic [11:0] rowOut;
  logic [9:0]  colOut;
  logic        err;
  logic [3:0]  bankOpen;
  logic [47:0] openRows;
  logic        modeValid;
  logic [13:0] modeReg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [2:0] P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100,
                         P_PRE = 3'b010, P_REF = 3'b001, P_MRS = 3'b000,
                         P_NOP = 3'b111, P_BST = 3'b110;

  always #5 clk = ~clk;

  sdram_cmd_tracker u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .cmdOut(cmdOut), .bankOut(bankOut), .rowOut(rowOut),
    .colOut(colOut), .err(err), .bankOpen(bankOpen), .openRows(openRows),
    .modeValid(modeValid), .modeReg(modeReg)
  );

  // Behavioural reference model
  int mOpen[4];
  int mRow[4];
  int mCnt[4];
  int mValid, mMode;
  int eCmd, eErr, eBank, eRow, eCol;

  function automatic int lenOf(int m);
    if ((m >> 9) % 2 == 1) return 1;
    case (m % 8)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < 4; k++) begin mOpen[k] = 0; mRow[k] = 0; mCnt[k] = 0; end
      mValid = 0; mMode = 0;
      eCmd = 0; eErr = 0; eBank = 0; eRow = 0; eCol = 0;
    end else begin
      int c, b, a, busy, e;
      a = int'(addr);
      b = a / 4096;
      c = 0;
      if (!csN) begin
        case ({rasN, casN, weN})
          P_ACT: c = 1;
          P_RD:  c = 2;
          P_WR:  c = ((a >> 10) % 2 == 1) ? 4 : 3;
          P_PRE: c = ((a >> 10) % 2 == 1) ? 6 : 5;
          P_REF: c = 7;
          P_MRS: c = 8;
          default: c = 0;
        endcase
      end
      busy = 0;
      for (int k = 0; k < 4; k++) if (mOpen[k] != 0) busy = 1;
      e = 0;
      if (c == 1) e = (mValid == 0 || mOpen[b] != 0) ? 1 : 0;
      if (c == 2 || c == 3 || c == 4)
        e = (mValid == 0 || mOpen[b] == 0 || mCnt[b] != 0) ? 1 : 0;
      if (c == 4 && lenOf(mMode) == 0) e = 1;
      if (c == 5 && mCnt[b] != 0) e = 1;
      if (c == 7 && busy != 0) e = 1;
      for (int k = 0; k < 4; k++)
        if (mCnt[k] > 0) begin
          mCnt[k]--;
          if (mCnt[k] == 0) mOpen[k] = 0;
        end
      if (e == 0) begin
        case (c)
          1: begin mOpen[b] = 1; mRow[b] = a % 4096; end
          4: mCnt[b] = lenOf(mMode);
          5: mOpen[b] = 0;
          6: for (int k = 0; k < 4; k++) begin mOpen[k] = 0; mCnt[k] = 0; end
          8: begin mValid = 1; mMode = a; end
          default: ;
        endcase
      end
      eCmd = c; eErr = e; eBank = b; eRow = a % 4096; eCol = a % 1024;
    end
  end

  task automatic want(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      int ov;
      ov = 0;
      for (int k = 0; k < 4; k++) if (mOpen[k] != 0) ov += (1 << k);
      want("R2 cmdOut vs model", int'(cmdOut), eCmd);
      want("R3 bankOut vs model", int'(bankOut), eBank);
      want("R2 rowOut vs model", int'(rowOut), eRow);
      want("R2 colOut vs model", int'(colOut), eCol);
      want("R13 err vs model", int'(err), eErr);
      want("R4 bankOpen vs model", int'(bankOpen), ov);
      for (int k = 0; k < 4; k++)
        want("R4 openRows vs model", int'(openRows[k*12 +: 12]), mRow[k]);
      want("R7 modeValid vs model", int'(modeValid), mValid);
      want("R7 modeReg vs model", int'(modeReg), mMode);
    end
  end

  // Called at a falling edge; returns at the next falling edge.
  task automatic issue(input logic [2:0] pins, input logic [13:0] a);
    csN = 1'b0;
    {rasN, casN, weN} = pins;
    addr = a;
    @(negedge clk);
  endtask

  task automatic idle();
    issue(P_NOP, 14'h0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    want("R1 reset bankOpen", int'(bankOpen), 0);
    want("R1 reset modeValid", int'(modeValid), 0);
    want("R1 reset cmdOut", int'(cmdOut), 0);
    want("R1 reset err", int'(err), 0);
    rstN = 1'b1;
    @(negedge clk);
    want("R1 idle after reset", int'(bankOpen), 0);

    issue(P_ACT, 14'h0123);
    want("R8 activate before mode err", int'(err), 1);
    want("R8 bank stays closed", int'(bankOpen), 0);
    issue(P_RD, 14'h0000);
    want("R8 read before mode err", int'(err), 1);
    issue(P_REF, 14'h0000);
    want("R10 refresh idle legal", int'(err), 0);
    want("R2 refresh code", int'(cmdOut), 7);

    issue(P_MRS, 14'h0002);
    want("R7 mode stored", int'(modeReg), 2);
    want("R7 mode valid", int'(modeValid), 1);
    issue(P_ACT, 14'h0123);
    want("R4 bank0 open", int'(bankOpen), 1);
    want("R4 row recorded", int'(openRows[11:0]), 'h123);
    want("R2 activate code", int'(cmdOut), 1);
    issue(P_ACT, 14'h3ABC);
    want("R3 bank index 3", int'(bankOut), 3);
    want("R4 bank3 open", int'(bankOpen), 'b1001);
    want("R4 bank3 row", int'(openRows[47:36]), 'hABC);
    issue(P_ACT, 14'h0555);
    want("R9 activate open bank err", int'(err), 1);
    want("R9 row kept", int'(openRows[11:0]), 'h123);
    issue(P_RD, 14'h1000);
    want("R9 read closed bank err", int'(err), 1);
    want("R2 read code", int'(cmdOut), 2);
    issue(P_WR, 14'h0007);
    want("R13 err drops after one cycle", int'(err), 0);
    want("R2 write code", int'(cmdOut), 3);
    want("R2 column field", int'(colOut), 7);
    issue(P_REF, 14'h0000);
    want("R10 refresh with open bank err", int'(err), 1);
    want("R10 banks unchanged", int'(bankOpen), 'b1001);
    issue(P_PRE, 14'h3000);
    want("R5 only bank3 closed", int'(bankOpen), 'b0001);
    want("R2 precharge code", int'(cmdOut), 5);
    issue(P_PRE, 14'h2000);
    want("R5 precharge closed bank legal", int'(err), 0);

    csN = 1'b1; {rasN, casN, weN} = P_ACT; addr = 14'h1111;
    @(negedge clk);
    want("R2 deselect is nop", int'(cmdOut), 0);
    want("R2 deselect ignored", int'(bankOpen), 'b0001);
    issue(P_BST, 14'h0000);
    want("R2 pattern 110 is nop", int'(cmdOut), 0);

    // burst 4 auto-precharge, activate another bank on the closing edge
    issue(P_WR, 14'h0400);
    want("R2 write autoprecharge code", int'(cmdOut), 4);
    want("R12 pending bank reads open", int'(bankOpen), 'b0001);
    issue(P_RD, 14'h0000);
    want("R12 access to pending bank err", int'(err), 1);
    idle();
    idle();
    want("R12 still open before L edges", int'(bankOpen), 'b0001);
    issue(P_ACT, 14'h1222);
    want("R12 close and activate same edge", int'(bankOpen), 'b0010);
    want("R12 activate legal on closing edge", int'(err), 0);

    // full page burst
    issue(P_MRS, 14'h0007);
    issue(P_ACT, 14'h2333);
    want("R4 bank2 open", int'(bankOpen), 'b0110);
    issue(P_WR, 14'h2400);
    want("R11 full page autoprecharge err", int'(err), 1);
    idle();
    want("R11 bank stays open", int'(bankOpen), 'b0110);
    issue(P_MRS, 14'h0005);
    issue(P_WR, 14'h2400);
    want("R11 reserved burst code err", int'(err), 1);

    // single write mode
    issue(P_MRS, 14'h0207);
    issue(P_WR, 14'h2400);
    want("R12 single write mode legal", int'(err), 0);
    idle();
    want("R12 single write closes after 1", int'(bankOpen), 'b0010);

    // burst 8 cancelled by precharge-all
    issue(P_MRS, 14'h0003);
    issue(P_ACT, 14'h0010);
    issue(P_WR, 14'h0400);
    idle();
    issue(P_PRE, 14'h0400);
    want("R6 precharge all code", int'(cmdOut), 6);
    want("R6 all closed", int'(bankOpen), 0);
    want("R6 no error", int'(err), 0);
    issue(P_ACT, 14'h0011);
    want("R6 pending cancelled, activate legal", int'(err), 0);
    repeat (9) idle();
    want("R6 cancelled countdown does not close", int'(bankOpen), 'b0001);

    // burst 2
    issue(P_MRS, 14'h0001);
    issue(P_WR, 14'h0400);
    idle();
    want("R12 burst 2 open after 1", int'(bankOpen), 'b0001);
    idle();
    want("R12 burst 2 closed after 2", int'(bankOpen), 0);

    // burst 1
    issue(P_MRS, 14'h0000);
    issue(P_ACT, 14'h0000);
    issue(P_WR, 14'h0400);
    idle();
    want("R12 burst 1 closed after 1", int'(bankOpen), 0);
    idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule